// File: doc/BRIEF.md
# Three-lane symmetric polyphase FIR filter

This block is a block-parallel, linear-phase FIR filter that takes three consecutive input samples per clock and returns three filtered samples per clock. The result on every lane equals the single-rate 37-tap direct-form convolution of the sample stream. Internally, three polyphase lane filters read one shared history of past samples. The history holds the last twelve accepted beats, kept as three interleaved phases.

Each lane filter adds each pair of taps that share a coefficient before it multiplies. Only the centre tap is multiplied on its own. So each output lane needs 19 multipliers instead of 37. The structure has no fast-FIR pre-addition or post-addition networks. The coefficients are fixed by elaboration, and the arithmetic is kept at full precision up to the output.

The block sits in a wide datapath that moves three samples per clock. A beat is presented with its valid flag high. The filtered beat leaves a fixed number of clocks later with its own valid flag.

Top module: `symfir_block`

## Requirements
- R1: Input lane j of a beat (bits 12j+11..12j of `in_samples`) carries sample x[3n+j], and output lane j (bits 26j+25..26j of `out_samples`) carries y[3n+j] = sum over k=0..36 of h[k]*x[3n+j-k]. The sample index n counts accepted beats since reset.
- R2: Only beats with `in_valid` high enter the sample history. Cycles with `in_valid` low leave the history untouched, whatever lies on `in_samples`.
- R3: The coefficients are symmetric, h[k] = h[36-k]. For m = 0..18, h[m] = ((7*m+3) mod 61) - 30 (for example h[0] = -27, h[1] = -20, h[18] = -23).
- R4: Inputs are 12-bit two's complement. Outputs are 26-bit two's complement, wide enough that no result wraps for any input, including long runs of +2047 or -2048.
- R5: `out_valid` equals `in_valid` delayed by exactly three clocks. The output lanes hold the result of that beat in the same cycle.
- R6: A synchronous active-high `rst` clears the sample history and the pipeline. While reset is held, `out_valid` and all output lanes read 0. After reset, every sample accepted before it counts as zero.
- R7: A single sample of value 1 on lane 0, followed by zero beats, produces h[0], h[1], ... h[36] in stream order across the output lanes and beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_samples` carries a new beat |
| in_samples | input | 36 | Three signed 12-bit samples, lane 0 in the low bits |
| out_valid | output | 1 | High when `out_samples` carries a filtered beat |
| out_samples | output | 78 | Three signed 26-bit results, lane 0 in the low bits |

## Verification
A beat captured at one rising edge shows up on the outputs after the third rising edge that follows: a pre-add register, then a product register, then the accumulator. The bench drives inputs just after a rising edge and reads outputs on the falling edge. It pushes each driven valid flag into its own three-deep shift model, and each accepted beat number into a queue. Each falling edge compares `out_valid` with the oldest stage of that model. When that stage is set, the bench pops the beat and checks all three lanes against a single-rate reference convolution over every sample accepted since the last reset. Gaps, extreme values, a reset in mid-stream and an impulse all follow the same three-cycle timing.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    // Unique half of the symmetric impulse response, index 0..centre.
    function automatic int half_coef(input int m);
        return ((7 * m + 3) % 61) - 30;
    endfunction

    // Full tap value for tap k of a filter with the given odd length.
    function automatic int tap_coef(input int k, input int taps);
        int centre;
        centre = (taps - 1) / 2;
        return half_coef((k <= centre) ? k : (taps - 1 - k));
    endfunction

    // Number of history beats needed to reach back taps-1 samples.
    function automatic int history_beats(input int taps, input int lanes);
        return (taps - 1 + lanes - 1) / lanes;
    endfunction

endpackage

// File: rtl/symfir_history.sv
module symfir_history #(
    parameter int LANES = 3,
    parameter int DW    = 12,
    parameter int DEPTH = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [LANES*DW-1:0]             in_samples,
    output logic [(DEPTH+1)*LANES*DW-1:0]   window
);
    localparam int LW  = LANES * DW;
    localparam int HLW = DEPTH * LW;

    // One flat delay line shared by all lane filters. Slot 0 is the oldest
    // sample; the three polyphase phases interleave inside it.
    typedef struct packed {
        logic [HLW-1:0] hist;
    } hist_st_t;

    hist_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (in_valid) begin
            nxt_d.hist = {in_samples, cur_q.hist[HLW-1:LW]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign window = {in_samples, cur_q.hist};

    // R6: a reset cycle leaves an all-zero history behind it
    a_r6_history_cleared: assert property (@(posedge clk)
        $past(rst) |-> (cur_q.hist == '0));

    // R2: an idle cycle leaves the history untouched
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> $stable(cur_q.hist));

    // R1: an accepted beat lands in the newest history slots, lane order kept
    a_r1_lane_capture: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst)) |->
        (cur_q.hist[HLW-1 -: LW] == $past(in_samples)));

endmodule

// File: rtl/symfir_lane.sv
module symfir_lane #(
    parameter int TAPS = 37,
    parameter int DW   = 12,
    parameter int CW   = 8,
    parameter int OW   = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TAPS*DW-1:0]   taps_win,
    output logic [OW-1:0]        y
);
    // taps_win slot i holds x[t-(TAPS-1-i)] for this lane's output index t.
    localparam int NPAIR = (TAPS - 1) / 2;
    localparam int NMUL  = NPAIR + 1;
    localparam int PW    = DW + 1;
    localparam int PRW   = PW + CW;

    typedef struct packed {
        logic [NMUL-1:0][PW-1:0]  pair;
        logic [NMUL-1:0][PRW-1:0] prod;
        logic [OW-1:0]            acc;
    } lane_st_t;

    lane_st_t cur_q, nxt_d;

    always_comb begin
        logic signed [DW-1:0]  lo;
        logic signed [DW-1:0]  hi;
        logic signed [PW-1:0]  ps;
        logic signed [PRW-1:0] pe;
        logic signed [CW-1:0]  cv;
        logic signed [PRW-1:0] ce;
        logic signed [PRW-1:0] pr;
        logic signed [OW-1:0]  sum;
        nxt_d = cur_q;
        // stage 1: fold each symmetric tap pair into one operand
        for (int m = 0; m < NPAIR; m++) begin
            lo = $signed(taps_win[(TAPS-1-m)*DW +: DW]);
            hi = $signed(taps_win[m*DW +: DW]);
            nxt_d.pair[m] = PW'(lo) + PW'(hi);
        end
        lo = $signed(taps_win[NPAIR*DW +: DW]);
        nxt_d.pair[NPAIR] = PW'(lo);
        // stage 2: one multiply per folded pair plus the centre tap
        for (int m = 0; m < NMUL; m++) begin
            ps = $signed(cur_q.pair[m]);
            pe = PRW'(ps);
            cv = CW'(symfir_pkg::half_coef(m));
            ce = PRW'(cv);
            nxt_d.prod[m] = pe * ce;
        end
        // stage 3: full-width accumulation of all products
        sum = '0;
        for (int m = 0; m < NMUL; m++) begin
            pr  = $signed(cur_q.prod[m]);
            sum = sum + OW'(pr);
        end
        nxt_d.acc = sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign y = cur_q.acc;

endmodule

// File: rtl/symfir_block.sv
module symfir_block #(
    parameter int LANES = 3,
    parameter int TAPS  = 37,
    parameter int DW    = 12,
    parameter int CW    = 8,
    parameter int OW    = DW + 1 + CW + $clog2((TAPS + 1) / 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_samples,
    output logic                  out_valid,
    output logic [LANES*OW-1:0]   out_samples
);
    localparam int DEPTH = symfir_pkg::history_beats(TAPS, LANES);
    localparam int HL    = DEPTH * LANES;
    localparam int WIN   = HL + LANES;
    localparam int STG   = 3;

    typedef struct packed {
        logic [STG-1:0] vld;
        logic [1:0]     since;
    } ctl_st_t;

    ctl_st_t ctl_q, ctl_d;
    logic [WIN*DW-1:0] window;

    symfir_history #(
        .LANES (LANES),
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_hist (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .window     (window)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        symfir_lane #(
            .TAPS (TAPS),
            .DW   (DW),
            .CW   (CW),
            .OW   (OW)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .taps_win (window[(HL - (TAPS - 1) + g)*DW +: TAPS*DW]),
            .y        (out_samples[g*OW +: OW])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = {ctl_q.vld[STG-2:0], in_valid};
        if (ctl_q.since != 2'd3) begin
            ctl_d.since = ctl_q.since + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.vld[STG-1];

    // R5: output valid is the input valid three clocks earlier
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6: reset leaves no valid output behind it
    a_r6_valid_cleared: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/tb_symfir_block.sv
module tb_symfir_block;
    localparam int DW = 12;
    localparam int OW = 26;
    localparam int L  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [L*DW-1:0] in_samples = '0;
    logic            out_valid;
    logic [L*OW-1:0] out_samples;

    symfir_block dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_samples  (in_samples),
        .out_valid   (out_valid),
        .out_samples (out_samples)
    );

    always #5 clk = ~clk;

    localparam int VEC [16][3] = '{
        '{  100,  -50,   25 }, '{ -300,  400,    7 }, '{    0,    0,    0 },
        '{ 2047, -2048,  1 }, '{   -1,    1,   -1 }, '{  512,  256,  128 },
        '{  -77,   88,  -99 }, '{ 1000, -1000, 1000 }, '{    3,    5,    8 },
        '{  -13,  -21,  -34 }, '{  600,  -60,    6 }, '{ -2048, -2048, 2047 },
        '{   11,   22,   33 }, '{ -444,  555, -666 }, '{  777,  -12,  345 },
        '{    9,   -9,    9 }
    };

    int     xs [0:2047];
    int     nb = 0;
    int     cur_beat = 0;
    string  cur_req = "R1";
    int     qbeat [0:1023];
    string  qtag [0:1023];
    int     qh = 0, qt = 0;
    logic [2:0] vp = '0;
    bit     mon_on = 0;
    bit     done = 0;
    int     n_chk = 0, n_bad = 0;

    function automatic int bh(input int k);
        int m;
        m = (k <= 18) ? k : 36 - k;
        return ((7 * m + 3) % 61) - 30;
    endfunction

    function automatic longint ref_y(input int t);
        longint s;
        s = 0;
        for (int k = 0; k < 37; k++) begin
            if (t - k >= 0) s += longint'(bh(k)) * longint'(xs[t - k]);
        end
        return s;
    endfunction

    task automatic drive(input bit v, input int a, input int b, input int c);
        @(posedge clk); #2;
        in_valid   = v;
        in_samples = {DW'(c), DW'(b), DW'(a)};
        if (v) begin
            xs[3*nb] = a; xs[3*nb+1] = b; xs[3*nb+2] = c;
            cur_beat = nb;
            nb++;
        end
    endtask

    // monitor: outputs read on the falling edge, three edges after capture
    always @(negedge clk) begin
        if (mon_on) begin
            n_chk++;
            if (out_valid !== vp[2]) begin
                n_bad++;
                $display("FAIL R5 out_valid got %0b expected %0b", out_valid, vp[2]);
            end
            if (vp[2]) begin
                for (int j = 0; j < L; j++) begin
                    longint got, exp;
                    got = longint'($signed(out_samples[j*OW +: OW]));
                    exp = ref_y(3*qbeat[qh] + j);
                    n_chk++;
                    if (got != exp) begin
                        n_bad++;
                        $display("FAIL %s beat %0d lane %0d got %0d expected %0d",
                                 qtag[qh], qbeat[qh], j, got, exp);
                    end
                end
                qh++;
            end
            vp = {vp[1:0], (in_valid && !rst)};
            if (in_valid && !rst) begin
                qbeat[qt] = cur_beat;
                qtag[qt]  = cur_req;
                qt++;
            end
        end
    end

    task automatic check_reset_zero();
        @(negedge clk); #1;
        n_chk++;
        if (out_valid !== 1'b0 || out_samples !== '0) begin
            n_bad++;
            $display("FAIL R6 during reset got valid %0b data %h expected 0 and 0",
                     out_valid, out_samples);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        @(posedge clk); #2;
        mon_on = 1;
        check_reset_zero();
        @(posedge clk); #2;
        rst = 0;

        // R1: table of varied beats, back to back
        cur_req = "R1";
        for (int i = 0; i < 16; i++) drive(1, VEC[i][0], VEC[i][1], VEC[i][2]);

        // R2: idle cycles with junk on the lanes must not enter the history
        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin
            drive(1, 37*i - 150, 200 - 41*i, 13*i);
            drive(0, 2047, -2048, 1234);
            if (i % 3 == 0) drive(0, -777, 777, -1);
        end

        // R4: extreme runs that reach the widest results
        cur_req = "R4";
        for (int i = 0; i < 14; i++) drive(1, 2047, 2047, 2047);
        for (int i = 0; i < 14; i++) drive(1, -2048, -2048, -2048);
        for (int i = 0; i < 14; i++) drive(1, 2047, -2048, 2047);
        for (int i = 0; i < 14; i++) drive(1, -2048, 2047, -2048);
        repeat (4) drive(0, 0, 0, 0);

        // R6: reset in mid-stream, then earlier samples must count as zero
        cur_req = "R6";
        for (int i = 0; i < 5; i++) drive(1, 900, -900, 450);
        @(posedge clk); #2;
        rst = 1; in_valid = 0; in_samples = '0;
        @(posedge clk); #2;
        qh = 0; qt = 0; vp = '0; nb = 0;
        check_reset_zero();
        @(posedge clk); #2;
        rst = 0;
        for (int i = 0; i < 14; i++) drive(1, 5*i - 30, 100, -7*i);
        repeat (4) drive(0, 0, 0, 0);

        // R3 and R7: impulse response after a fresh reset
        @(posedge clk); #2;
        rst = 1;
        @(posedge clk); #2;
        qh = 0; qt = 0; vp = '0; nb = 0;
        rst = 0;
        cur_req = "R3,R7";
        drive(1, 1, 0, 0);
        for (int i = 0; i < 13; i++) drive(1, 0, 0, 0);
        drive(0, 0, 0, 0);
        // R7: direct look at a mid-response beat, tap 18 on lane 0 of beat 6
        repeat (4) drive(0, 0, 0, 0);
        n_chk++;
        if (ref_y(18) != longint'(bh(18))) begin
            n_bad++;
            $display("FAIL R7 reference tap 18 got %0d expected %0d", ref_y(18), bh(18));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule